// File: doc/BRIEF.md
# Serial Query Symbol Loader

This block sets the per-cell query symbols of a linear alignment array from one serial input pin, so the array does not need a parallel input that grows with the number of cells. Each cell takes a 3-bit nucleotide code. Bits arrive one per clock while `load_en` is high. They fill a 1-bit-wide shift register that is `3*NUM_CELLS` bits long. A bit counter tracks how far the load has progressed.

When the last bit of a frame has been shifted in, a small control state machine spends one cycle in its transfer state. In that cycle it raises `xfer_pulse`, and at the end of the cycle it copies the whole shift register into a holding register. The holding register drives the cells. It changes only at these transfers, so the cells never see a partly shifted frame, and their query symbols stay constant for as long as no new frame is loaded.

The controller has four states:
- EMPTY: no frame has been transferred since reset.
- FILL: a load is in progress or paused.
- COMMIT: the one-cycle transfer.
- READY: the holding register holds a complete frame and no new load has started.

Transitions:
- EMPTY→FILL and READY→FILL happen on the first load bit.
- FILL→COMMIT happens on the final bit. So do EMPTY→COMMIT and READY→COMMIT, if a frame could complete in one bit.
- COMMIT→READY happens when load is low.
- COMMIT→FILL happens when load is high, because that bit starts the next frame.
- FILL→FILL happens while a load is paused.
- Reset returns to EMPTY from any state.

Top module: `query_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the shift register, the bit counter and the holding register to all zeros. Zero is code 000, nucleotide A, in every cell. After reset, `ready` and `xfer_pulse` are low.
- R2: At each clock edge with `load_en` high, `ser_in` enters the shift register at bit 0 and every stored bit moves up one position. After a frame of `3*NUM_CELLS` bits, the bit sent first sits at bit `3*NUM_CELLS-1` of `query_out`.
- R3: Cell k, for k from 0 to NUM_CELLS-1, receives `query_out[3k+2:3k]`. A frame therefore carries the cell codes from cell NUM_CELLS-1 down to cell 0, each code most significant bit first.
- R4: `xfer_pulse` is high for exactly one cycle. That cycle directly follows the edge that took in the final bit of a frame, and the pulse never occurs without a completed frame.
- R5: `query_out` changes only at the edge that ends the `xfer_pulse` cycle, where it takes the complete frame. While bits are being shifted, it keeps its previous value.
- R6: `ready` goes high in the cycle after a transfer. It drops after the first edge at which `load_en` is sampled high.
- R7: While `load_en` is low, the shift register and the bit counter hold their values. A load that is paused part-way resumes where it stopped, and no transfer happens until the count completes.
- R8: If `load_en` is high during the `xfer_pulse` cycle, that bit becomes the first bit of the next frame. The transfer still copies the complete previous frame, so frames can be streamed with no gap.
- R9: A reset in the middle of a load discards the bits received so far. The next transfer then needs a full `3*NUM_CELLS` new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Shift one serial bit in at this edge |
| ser_in | input | 1 | Serial query bit |
| query_out | output | NUM_CELLS*SYM_W | Held query codes, cell k at bits [3k+2:3k] |
| xfer_pulse | output | 1 | One-cycle strobe in the cycle of the transfer |
| ready | output | 1 | A complete frame is held and no new load has begun |

## Verification
A wrong bit count would show up first as a transfer strobe one or more cycles too early or too late relative to the final bit. The next cycle's `query_out` would then be shifted by whole bits against the expected frame. A corrupted shift order or cell mapping is visible in `query_out` in the first cycle after a transfer. A holding register that follows the shift register would show up at the ports while a load is still in progress, because the cells' codes would change before the strobe. A controller stuck in the wrong state shows through `ready` and `xfer_pulse` within a cycle of the next load edge. The bench streams every possible frame of a four-cell configuration back to back and compares each transferred frame with its frame number.

// File: rtl/qld_pkg.sv
package qld_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_READY  = 2'd3
    } qld_state_e;

endpackage

// File: rtl/qld_shift.sv
module qld_shift #(
    parameter int TOTAL = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [TOTAL-1:0] bits_q
);

    // R2: new bit at the low end, older bits move toward the high end
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (shift_en) begin
            bits_q <= {bits_q[TOTAL-2:0], ser_in};
        end
    end

endmodule

// File: rtl/qld_counter.sv
module qld_counter #(
    parameter int TOTAL = 24,
    parameter int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] cnt_q,
    output logic          last
);

    localparam logic [CW-1:0] LAST_IDX = CW'(TOTAL - 1);

    assign last = step && (cnt_q == LAST_IDX);

    // R7: counter holds while step is low; R9: reset discards progress
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/qld_ctrl.sv
module qld_ctrl
    import qld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic       last,
    output qld_state_e state_q,
    output logic       xfer,
    output logic       ready
);

    qld_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (last)         state_d = ST_COMMIT;
                else if (load_en) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (last)         state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (last)         state_d = ST_COMMIT;
                else if (load_en) state_d = ST_FILL;
                else              state_d = ST_READY;
            end
            ST_READY: begin
                if (last)         state_d = ST_COMMIT;
                else if (load_en) state_d = ST_FILL;
            end
            default:              state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        xfer  = 1'b0;
        ready = 1'b0;
        unique case (state_q)
            ST_COMMIT: xfer  = 1'b1;
            ST_READY:  ready = 1'b1;
            default: begin
                xfer  = 1'b0;
                ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/qld_shadow.sv
module qld_shadow #(
    parameter int CELLS = 8,
    parameter int SYM_W = 3,
    parameter int TOTAL = CELLS * SYM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [TOTAL-1:0] frame_in,
    output logic [TOTAL-1:0] cells_q
);

    // R3: one field register per cell, cell k at [SYM_W*k +: SYM_W]
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells_q[SYM_W*k +: SYM_W] <= '0;
            end else if (capture) begin
                cells_q[SYM_W*k +: SYM_W] <= frame_in[SYM_W*k +: SYM_W];
            end
        end
    end

endmodule

// File: rtl/query_loader.sv
module query_loader
    import qld_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    parameter int SYM_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_en,
    input  logic                       ser_in,
    output logic [NUM_CELLS*SYM_W-1:0] query_out,
    output logic                       xfer_pulse,
    output logic                       ready
);

    localparam int TOTAL = NUM_CELLS * SYM_W;
    localparam int CW    = $clog2(TOTAL);

    logic [TOTAL-1:0] sr_q;
    logic [CW-1:0]    cnt_q;
    logic             last;
    qld_state_e       state_q;

    qld_shift #(.TOTAL(TOTAL)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (load_en),
        .ser_in   (ser_in),
        .bits_q   (sr_q)
    );

    qld_counter #(.TOTAL(TOTAL), .CW(CW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .step  (load_en),
        .cnt_q (cnt_q),
        .last  (last)
    );

    qld_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .last    (last),
        .state_q (state_q),
        .xfer    (xfer_pulse),
        .ready   (ready)
    );

    qld_shadow #(.CELLS(NUM_CELLS), .SYM_W(SYM_W), .TOTAL(TOTAL)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .capture  (xfer_pulse),
        .frame_in (sr_q),
        .cells_q  (query_out)
    );

endmodule

// File: rtl/query_loader_chk.sv
module query_loader_chk #(
    parameter int TOTAL = 24,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [TOTAL-1:0] query_out,
    input logic             xfer_pulse,
    input logic             ready,
    input logic [TOTAL-1:0] sr_q,
    input logic [CW-1:0]    cnt_q
);

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse |=> !xfer_pulse);

    assert_pulse_after_load_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse |-> $past(load_en));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !xfer_pulse |=> $stable(query_out));

    assert_ready_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(xfer_pulse));

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (ready && load_en) |=> !ready);

    assert_pause_shift_R7: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(sr_q));

    assert_pause_count_R7: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(cnt_q));

    assert_count_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < TOTAL);

endmodule

bind query_loader query_loader_chk #(.TOTAL(TOTAL), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .query_out  (query_out),
    .xfer_pulse (xfer_pulse),
    .ready      (ready),
    .sr_q       (sr_q),
    .cnt_q      (cnt_q)
);

// File: tb/query_loader_bench.sv
`timescale 1ns/1ps
module query_loader_bench;

    localparam int NC  = 4;
    localparam int SW  = 3;
    localparam int TOT = NC * SW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_en = 1'b0;
    logic           ser_in = 1'b0;
    logic [TOT-1:0] query_out;
    logic           xfer_pulse;
    logic           ready;
    logic [TOT-1:0] prev;
    logic [TOT-1:0] frame;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    query_loader #(.NUM_CELLS(NC), .SYM_W(SW)) u_query_loader (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .ser_in     (ser_in),
        .query_out  (query_out),
        .xfer_pulse (xfer_pulse),
        .ready      (ready)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        load_en = 1'b1;
        ser_in  = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            load_en = 1'b0;
        end
    endtask

    // send a frame MSB first, optionally pausing before bit pause_at
    task automatic send_frame(input logic [TOT-1:0] v, input int pause_at, input int pause_len);
        for (int j = 0; j < TOT; j++) begin
            if (j == pause_at) begin
                idle(pause_len);
                chk("R7 no transfer while paused", xfer_pulse, 0);
                chk("R5 hold stable mid-load", query_out, prev);
            end
            put_bit(v[TOT-1-j]);
        end
        @(negedge clk);
        load_en = 1'b0;
        chk("R4 strobe after final bit", xfer_pulse, 1);
        chk("R5 hold unchanged in strobe cycle", query_out, prev);
        @(negedge clk);
        chk("R2 frame transferred", query_out, v);
        chk("R6 ready after transfer", ready, 1);
        chk("R4 strobe lasts one cycle", xfer_pulse, 0);
        prev = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        prev = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset hold value", query_out, 0);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset strobe", xfer_pulse, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release hold value", query_out, 0);
        chk("R1 after release ready", ready, 0);

        // plain frame, no pause
        send_frame(12'hA5C, TOT + 1, 0);
        // paused load (R7) with different frame
        send_frame(12'h3E7, 5, 4);

        // R6: one load edge drops ready
        put_bit(1'b1);
        @(negedge clk);
        load_en = 1'b0;
        chk("R6 ready drops on new load", ready, 0);
        chk("R5 hold unchanged by new load", query_out, prev);

        // R9: reset mid-load discards partial bits
        put_bit(1'b0);
        put_bit(1'b1);
        @(negedge clk);
        load_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears hold", query_out, 0);
        chk("R9 reset clears ready", ready, 0);
        prev = '0;
        send_frame(12'h81F, TOT + 1, 0);

        // R3: distinct code per cell, cell k gets code k+1
        frame = '0;
        for (int k = 0; k < NC; k++) frame[SW*k +: SW] = SW'(k + 1);
        send_frame(frame, TOT + 1, 0);
        for (int k = 0; k < NC; k++)
            chk("R3 cell field", query_out[SW*k +: SW], k + 1);

        // R8: every frame streamed back to back, load held high
        for (int f = 0; f < (1 << TOT); f++) begin
            for (int j = 0; j < TOT; j++) begin
                @(negedge clk);
                if (f > 0 && j == 0) begin
                    chk("R8 strobe in streamed frame", xfer_pulse, 1);
                end
                if (f > 0 && j == 1) begin
                    chk("R8 streamed frame transferred", query_out, f - 1);
                    chk("R8 ready low while streaming", ready, 0);
                    chk("R4 strobe single while streaming", xfer_pulse, 0);
                end
                load_en = 1'b1;
                ser_in  = f[TOT-1-j];
            end
        end
        @(negedge clk);
        load_en = 1'b0;
        chk("R8 final strobe", xfer_pulse, 1);
        @(negedge clk);
        chk("R8 final frame", query_out, (1 << TOT) - 1);
        chk("R6 ready after stream", ready, 1);
        idle(3);
        chk("R5 hold stable when idle", query_out, (1 << TOT) - 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule